// File: doc/BRIEF.md
# 24-bit Three-Wire SPI Register Master

This block lets on-chip logic read and write the 16-bit configuration registers of an external display bridge over a three-wire serial link. Each wire transaction is a 24-bit frame. A frame sits inside its own chip-select window and is shifted out most-significant bit first. Every register access uses exactly two frames. The first frame selects the register. The second frame either carries the value to store, or asks the bridge to return the register contents on a separate input line.

The host side is a plain request/acknowledge pair. The host presents a register number, write data and a read flag, and pulses `req` while `busy` is low. When the second frame has fully closed, `ack` pulses for one cycle, and for reads `rdata` holds the captured value at that point. The serial bit rate and the chip-select guard times are set by the parameter `HALF_CYC`, the length of half a bit period in system-clock cycles. The parameter `HAS_MISO` states whether the return line is wired at all.

Top module: `spi24_reg_master`

## Requirements
- R1: Every frame holds exactly 24 bits and is sent most-significant bit first. `spi_mosi` presents each bit while `spi_sck` is low, and the bit is valid at the following rising edge of `spi_sck`.
- R2: The first frame of an access is the select frame. Bits 23..16 are 0x70, bits 15..8 are zero, and bits 7..0 are `reg_addr`.
- R3: For a write (`rw`=0), the second frame has 0x72 in bits 23..16 and `wdata` in bits 15..0.
- R4: For a read (`rw`=1), the second frame has 0x73 in bits 23..16 and zeros below. With `HAS_MISO`=1, `rdata` equals the lowest 16 of the 24 bits captured from `spi_miso` during that frame, first captured bit as bit 23.
- R5: Each bit keeps `spi_sck` low for `HAC_CYC`=`HALF_CYC` clock cycles and then high for `HALF_CYC` cycles. `spi_miso` is sampled in the last low cycle.
- R6: After `spi_cs_n` falls, `spi_sck` stays high for 2·`HALF_CYC` cycles before the first bit. After the last bit's high half, `spi_cs_n` stays low for another 2·`HALF_CYC` cycles. It then stays high for at least 2·`HALF_CYC` cycles before the next frame.
- R7: After reset and whenever no frame is open, `spi_cs_n`, `spi_sck` and `spi_mosi` are all high, and `busy` and `ack` are low.
- R8: With `HAS_MISO`=0, a read returns `rdata` = 0 whatever level `spi_miso` has.
- R9: `ack` is high for exactly one cycle, after the second frame's closing guard time. `busy` is high from the cycle after `req` is accepted until `ack`.
- R10: An access produces exactly two frames, with `spi_cs_n` high between them. A `req` raised while `busy` is high is ignored: it produces no frames and does not change the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start an access (taken only while busy is low) |
| rw | input | 1 | 1 = read, 0 = write |
| reg_addr | input | 8 | Register number |
| wdata | input | 16 | Value to write |
| busy | output | 1 | Access in progress |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid from ack |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the bridge |
| spi_miso | input | 1 | Serial data from the bridge |

## Verification
A pin-level monitor decodes every frame and measures the length of each serial clock phase and guard window. It runs under a seeded random mix of reads and writes with random register numbers, data and return patterns. Directed cases cover the all-zero and all-ones data words, which separate bit-order and opcode errors from stuck lines. A return pattern whose top byte differs from its low half shows whether `rdata` really takes the lowest 16 bits. A request raised mid-access shows whether the busy guard holds. A second instance, with the minimum half-bit length and the return line marked absent, checks the zero read result and the one-cycle timing edge.

// File: rtl/spi24_pkg.sv
// Package: shared opcodes, frame phases and access states for the
// 24-bit three-wire register master. Assumes 8-bit register numbers
// and 16-bit register values.
package spi24_pkg;

    localparam int FRAME_BITS = 24;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 16;

    localparam logic [7:0] OP_SELECT = 8'h70;
    localparam logic [7:0] OP_WRITE  = 8'h72;
    localparam logic [7:0] OP_READ   = 8'h73;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_LOW,
        PH_HIGH,
        PH_TRAIL,
        PH_GAP
    } phase_e;

    typedef enum logic [1:0] {
        AS_IDLE,
        AS_SELECT,
        AS_DATA
    } acc_state_e;

    // Builds the select frame for a register number.
    function automatic logic [FRAME_BITS-1:0] select_frame(input logic [ADDR_W-1:0] a);
        return {OP_SELECT, 8'h00, a};
    endfunction

    // Builds the second frame from the direction and write value.
    function automatic logic [FRAME_BITS-1:0] data_frame(input logic is_rd,
                                                         input logic [DATA_W-1:0] d);
        return is_rd ? {OP_READ, {DATA_W{1'b0}}} : {OP_WRITE, d};
    endfunction

endpackage

// File: rtl/spi24_frame_engine.sv
// Frame engine: sends one 24-bit frame MSB first in its own chip-select
// window and captures 24 bits from the return line. Assumes HALF_CYC >= 1
// and that start is only raised while the engine is idle.
module spi24_frame_engine
    import spi24_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame_in,
    output logic                  done,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  cs_n,
    output logic                  sck,
    output logic                  mosi,
    input  logic                  miso
);
    localparam int CNT_W  = $clog2(2 * HALF_CYC + 1);
    localparam int IDX_W  = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] HALF_LAST  = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] GUARD_LAST = CNT_W'(2 * HALF_CYC - 1);
    localparam logic [IDX_W-1:0] BIT_LAST   = IDX_W'(FRAME_BITS - 1);

    phase_e                ph;
    logic [CNT_W-1:0]      cnt;
    logic [IDX_W-1:0]      bit_idx;
    logic [FRAME_BITS-1:0] tx_sr;
    logic [FRAME_BITS-1:0] rx_sr;
    logic                  ph_end;

    // Picks the terminal count of the current phase.
    always_comb begin
        if (ph == PH_LOW || ph == PH_HIGH) ph_end = (cnt == HALF_LAST);
        else                               ph_end = (cnt == GUARD_LAST);
    end

    // Phase sequencing through lead guard, bit halves, trail and gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_IDLE;
        end else begin
            case (ph)
                PH_IDLE:  if (start)  ph <= PH_LEAD;
                PH_LEAD:  if (ph_end) ph <= PH_LOW;
                PH_LOW:   if (ph_end) ph <= PH_HIGH;
                PH_HIGH:  if (ph_end) ph <= (bit_idx == BIT_LAST) ? PH_TRAIL : PH_LOW;
                PH_TRAIL: if (ph_end) ph <= PH_GAP;
                PH_GAP:   if (ph_end) ph <= PH_IDLE;
                default:  ph <= PH_IDLE;
            endcase
        end
    end

    // Cycle counter within the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || ph == PH_IDLE || ph_end) cnt <= '0;
        else                                    cnt <= cnt + 1'b1;
    end

    // Bit index and transmit shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx <= '0;
            tx_sr   <= '1;
        end else if (ph == PH_IDLE && start) begin
            bit_idx <= '0;
            tx_sr   <= frame_in;
        end else if (ph == PH_HIGH && ph_end) begin
            bit_idx <= bit_idx + 1'b1;
            tx_sr   <= {tx_sr[FRAME_BITS-2:0], 1'b1};
        end
    end

    // Samples the return line in the last cycle of each low half.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rx_sr <= '0;
        else if (ph == PH_LOW && ph_end) rx_sr <= {rx_sr[FRAME_BITS-2:0], miso};
    end

    // Pin levels derived from the phase.
    always_comb begin
        cs_n = (ph == PH_IDLE || ph == PH_GAP);
        sck  = (ph != PH_LOW);
        mosi = (ph == PH_LOW || ph == PH_HIGH) ? tx_sr[FRAME_BITS-1] : 1'b1;
    end

    assign done    = (ph == PH_GAP) && ph_end;
    assign rx_word = rx_sr;

    // R5: a low half lasts exactly HALF_CYC cycles
    a_r5_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_HIGH && $past(ph) == PH_LOW) |-> $past(cnt) == HALF_LAST);

    // R1: the trail guard starts only after the last bit
    a_r1_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_TRAIL && $past(ph) == PH_HIGH) |-> $past(bit_idx) == BIT_LAST);

    // R6: chip select rises only at the end of a full trail guard
    a_r6_trail_guard: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> ($past(ph) == PH_TRAIL && $past(cnt) == GUARD_LAST));

    // R10: a new frame is requested only while the engine is idle
    a_r10_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ph == PH_IDLE);

endmodule

// File: rtl/spi24_access_seq.sv
// Access sequencer: turns one host request into a select frame followed
// by a data or read frame, then raises a one-cycle ack. Assumes the
// frame engine reports done once per started frame.
module spi24_access_seq
    import spi24_pkg::*;
#(
    parameter bit HAS_MISO = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  rw,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic                  busy,
    output logic                  ack,
    output logic [DATA_W-1:0]     rdata,
    output logic                  start,
    output logic [FRAME_BITS-1:0] frame,
    input  logic                  done,
    input  logic [FRAME_BITS-1:0] rx_word
);
    acc_state_e        st;
    logic              lat_rw;
    logic [DATA_W-1:0] lat_wdata;

    // Access state machine with frame start pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= AS_IDLE;
            start <= 1'b0;
            frame <= '1;
        end else begin
            start <= 1'b0;
            case (st)
                AS_IDLE: if (req) begin
                    st    <= AS_SELECT;
                    start <= 1'b1;
                    frame <= select_frame(reg_addr);
                end
                AS_SELECT: if (done) begin
                    st    <= AS_DATA;
                    start <= 1'b1;
                    frame <= data_frame(lat_rw, lat_wdata);
                end
                AS_DATA: if (done) st <= AS_IDLE;
                default: st <= AS_IDLE;
            endcase
        end
    end

    // Latches the request fields when an access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_rw    <= 1'b0;
            lat_wdata <= '0;
        end else if (st == AS_IDLE && req) begin
            lat_rw    <= rw;
            lat_wdata <= wdata;
        end
    end

    // Completion pulse and read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack <= (st == AS_DATA) && done;
            if (st == AS_DATA && done && lat_rw)
                rdata <= HAS_MISO ? rx_word[DATA_W-1:0] : '0;
        end
    end

    assign busy = (st != AS_IDLE);

    // R9: ack lasts a single cycle
    a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R9: ack follows an access that was busy
    a_r9_ack_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(busy));

    // R10: ack only after the second frame has finished
    a_r10_second_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ($past(st) == AS_DATA && $past(done)));

    // R10: a request during busy leaves the latched access untouched
    a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> ($stable(lat_rw) && $stable(lat_wdata)));

    generate
        if (!HAS_MISO) begin : g_no_miso
            // R8: without a return line the read result stays zero
            a_r8_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
                ack |-> rdata == '0);
        end
    endgenerate

endmodule

// File: rtl/spi24_reg_master.sv
// Top: register master for a display bridge over a 24-bit three-wire
// serial link. Assumes HALF_CYC >= 1; HAS_MISO = 0 when the return line
// is not wired.
module spi24_reg_master
    import spi24_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter bit HAS_MISO = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              rw,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic                  f_start;
    logic [FRAME_BITS-1:0] f_word;
    logic                  f_done;
    logic [FRAME_BITS-1:0] f_rx;

    spi24_access_seq #(.HAS_MISO(HAS_MISO)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .rw       (rw),
        .reg_addr (reg_addr),
        .wdata    (wdata),
        .busy     (busy),
        .ack      (ack),
        .rdata    (rdata),
        .start    (f_start),
        .frame    (f_word),
        .done     (f_done),
        .rx_word  (f_rx)
    );

    spi24_frame_engine #(.HALF_CYC(HALF_CYC)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (f_start),
        .frame_in (f_word),
        .done     (f_done),
        .rx_word  (f_rx),
        .cs_n     (spi_cs_n),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .miso     (spi_miso)
    );

    // R7: no serial clock activity outside a chip-select window
    a_r7_sck_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (spi_sck && spi_mosi));

    initial begin
        assert (HALF_CYC >= 1) else $error("HALF_CYC must be at least 1");
    end

endmodule

// File: tb/test_spi24_reg_master.sv
module test_spi24_reg_master;
    localparam int H  = 2;
    localparam int H2 = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic        req = 1'b0, rw = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic        busy, ack, spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b1;
    logic [15:0] rdata;

    spi24_reg_master #(.HALF_CYC(H), .HAS_MISO(1'b1)) i_spi24_reg_master (
        .clk(clk), .rst_n(rst_n), .req(req), .rw(rw), .reg_addr(reg_addr),
        .wdata(wdata), .busy(busy), .ack(ack), .rdata(rdata),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso));

    logic        n_req = 1'b0;
    logic        n_busy, n_ack, n_cs, n_sck, n_mosi;
    logic [15:0] n_rdata;

    spi24_reg_master #(.HALF_CYC(H2), .HAS_MISO(1'b0)) i_spi24_reg_master_nomiso (
        .clk(clk), .rst_n(rst_n), .req(n_req), .rw(1'b1), .reg_addr(8'h0A),
        .wdata(16'h0000), .busy(n_busy), .ack(n_ack), .rdata(n_rdata),
        .spi_cs_n(n_cs), .spi_sck(n_sck), .spi_mosi(n_mosi),
        .spi_miso(1'b1));

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req_tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req_tag, what, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_select(input logic [7:0] a);
        return {8'h70, 8'h00, a};
    endfunction

    function automatic logic [23:0] exp_second(input logic r, input logic [15:0] d);
        return r ? 24'h730000 : {8'h72, d};
    endfunction

    // return-line model: next pattern bit on each falling sck
    logic [23:0] miso_pat = '0;
    int          mbit = 0;
    always @(negedge spi_cs_n) mbit = 0;
    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            spi_miso = miso_pat[23 - mbit];
            mbit++;
        end
    end

    // pin monitor, sampled mid-cycle
    logic [23:0] frames [0:7];
    int   fcount = 0;
    logic prev_cs = 1'b1, prev_sck = 1'b1, last_mosi = 1'b1;
    int   lead_cnt = 0, lo_cnt = 0, hi_cnt = 0, nbits = 0, gap_cnt = 0;
    int   idle_bad = 0;
    bit   seen_frame = 0;
    logic [23:0] cur = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_cs_n) begin
                if (!spi_sck || !spi_mosi) idle_bad++;
                if (!prev_cs) begin
                    check(nbits == 24, "R1", "bits in frame", nbits, 24);
                    check(hi_cnt == 3*H, "R6", "last high half plus trail guard", hi_cnt, 3*H);
                    if (fcount < 8) frames[fcount] = cur;
                    fcount++;
                    gap_cnt = 1;
                    seen_frame = 1;
                end else gap_cnt++;
            end else begin
                if (prev_cs) begin
                    if (seen_frame)
                        check(gap_cnt >= 2*H, "R6", "chip select high gap", gap_cnt, 2*H);
                    nbits = 0; lead_cnt = 1; hi_cnt = 0; cur = '0;
                end else if (spi_sck && prev_sck) begin
                    if (nbits == 0) lead_cnt++; else hi_cnt++;
                end else if (!spi_sck && prev_sck) begin
                    if (nbits == 0)
                        check(lead_cnt == 2*H, "R6", "lead guard", lead_cnt, 2*H);
                    else
                        check(hi_cnt == H, "R5", "sck high half", hi_cnt, H);
                    lo_cnt = 1; last_mosi = spi_mosi;
                end else if (!spi_sck && !prev_sck) begin
                    lo_cnt++;
                    if (spi_mosi !== last_mosi) idle_bad++;
                end else begin
                    check(lo_cnt == H, "R5", "sck low half", lo_cnt, H);
                    cur = {cur[22:0], last_mosi};
                    nbits++;
                    hi_cnt = 1;
                end
            end
            prev_cs = spi_cs_n;
            prev_sck = spi_sck;
        end
    end

    // one access: issue, wait ack, check frames and result
    task automatic do_access(input logic r, input logic [7:0] a, input logic [15:0] d,
                             input logic [23:0] pat, input bit poke_busy);
        int waited = 0;
        miso_pat = pat;
        fcount = 0;
        @(negedge clk);
        req = 1'b1; rw = r; reg_addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        check(busy == 1'b1, "R9", "busy after accept", busy, 1);
        if (poke_busy) begin
            repeat (10) @(negedge clk);
            req = 1'b1; rw = ~r; reg_addr = ~a; wdata = ~d;
            @(negedge clk);
            req = 1'b0;
        end
        while (!ack && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        check(ack == 1'b1, "R9", "ack arrived", ack, 1);
        check(fcount == 2, "R10", "frames per access", fcount, 2);
        check(frames[0] == exp_select(a), "R2", "select frame", frames[0], exp_select(a));
        if (r) begin
            check(frames[1] == exp_second(1'b1, d), "R4", "read frame", frames[1], exp_second(1'b1, d));
            check(rdata == pat[15:0], "R4", "read result", rdata, pat[15:0]);
        end else begin
            check(frames[1] == exp_second(1'b0, d), "R3", "write frame", frames[1], exp_second(1'b0, d));
        end
        check(spi_cs_n == 1'b1, "R9", "frame closed at ack", spi_cs_n, 1);
        @(negedge clk);
        check(ack == 1'b0, "R9", "ack one cycle", ack, 0);
        check(busy == 1'b0, "R9", "busy low after ack", busy, 0);
        if (poke_busy) begin
            repeat (60*H) @(negedge clk);
            check(fcount == 2, "R10", "request during busy ignored", fcount, 2);
            check(busy == 1'b0, "R10", "no access started by ignored request", busy, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        check(spi_cs_n && spi_sck && spi_mosi, "R7", "idle pins", {spi_cs_n, spi_sck, spi_mosi}, 3'b111);
        check(!busy && !ack, "R7", "idle handshake", {busy, ack}, 2'b00);

        // directed corners
        do_access(1'b0, 8'hB7, 16'h0000, 24'h0, 0);
        do_access(1'b0, 8'hFF, 16'hFFFF, 24'h0, 0);
        do_access(1'b1, 8'h00, 16'h0000, 24'hA5_1234, 0);
        do_access(1'b1, 8'hB0, 16'h0000, 24'hFF_0000, 0);
        do_access(1'b0, 8'h5A, 16'h8001, 24'h0, 1);
        do_access(1'b1, 8'hC6, 16'h0000, 24'h00_FFFF, 1);

        // random mix
        for (int i = 0; i < 20; i++) begin
            do_access(1'($urandom), 8'($urandom), 16'($urandom), 24'($urandom), 0);
        end

        repeat (4) @(negedge clk);
        check(idle_bad == 0, "R7", "pins high outside frames, data stable in low half", idle_bad, 0);

        // R8: second instance without a return line, minimum half-bit
        begin
            int waited = 0;
            @(negedge clk);
            n_req = 1'b1;
            @(negedge clk);
            n_req = 1'b0;
            while (!n_ack && waited < 2000) begin
                @(negedge clk);
                waited++;
            end
            check(n_ack == 1'b1, "R9", "ack with minimum half-bit", n_ack, 1);
            check(n_rdata == 16'h0000, "R8", "absent return line reads zero", n_rdata, 0);
            @(negedge clk);
            check(n_ack == 1'b0, "R9", "ack one cycle, minimum half-bit", n_ack, 0);
            check(n_cs && n_sck && n_mosi, "R7", "idle pins, second instance", {n_cs, n_sck, n_mosi}, 3'b111);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule